// File: doc/BRIEF.md
# SMBus Host Register Interface

This block is the byte-wide register bank that sits between a processor's simple read/write port and an SMBus bus engine. Software loads the slave address and direction, the command byte, up to two data bytes, the transaction kind and an option for hardware packet error checking. It then launches a transaction by setting the start bit in the control register. The block turns that write into a single-cycle start strobe for the engine and shows the host as busy. It records completion and error events in a status register whose bits are cleared by writing one.

Block transfers move one byte at a time through the block-data register. When the engine finishes a byte it raises a byte-done strobe. The block latches this as a status flag and holds the engine with `eng_hold`. The hold lasts until software has read or refilled the block-data register and written a one to the flag. The engine can also deposit received bytes into the data0, data1 and block-data registers.

A four-state machine tracks the host:

- **IDLE**: no transaction is running.
- **LAUNCH**: the one cycle in which the start strobe is driven.
- **RUN**: the engine is working.
- **HOLD**: the engine is stalled on a byte handshake.

Its transitions are:

- **IDLE→LAUNCH**: an accepted start write.
- **LAUNCH→RUN**: unconditional, when no event arrives.
- **LAUNCH/RUN→HOLD**: a byte-done strobe.
- **HOLD→RUN**: a status write with bit 7 set.
- **LAUNCH/RUN/HOLD→IDLE**: a done or error strobe. This has priority over every other transition.

Top module: `smb_host_regs`

## Requirements
- R1: After reset the status, control, command, address, data0, data1, block-data and auxiliary registers read 0, `eng_start` and `eng_hold` are 0, and `eng_count` is 1.
- R2: Registers sit at these offsets:
  - status at 0
  - control at 2 (only bits [5:2] are stored; bits 7, 6, 1 and 0 read 0)
  - command at 3
  - address at 4
  - data0 at 5
  - data1 at 6
  - block data at 7
  - auxiliary control at 13 (bit 0 only)

  All other offsets read 0 and ignore writes.
- R3: A write to control with bit 6 set while the host is idle makes `eng_start` high for exactly the one cycle after the write. Status bit 0 (busy) reads 1 from that cycle until the transaction ends.
- R4: A write to control with bit 6 set while busy is ignored: no start strobe is produced and the control contents are unchanged.
- R5: A pulse on `eng_done` ends the transaction (status bit 0 reads 0) and sets status bit 1.
- R6: A pulse on `eng_dev_err`, `eng_coll` or `eng_failed` sets status bit 2, 3 or 4 respectively and ends the transaction.
- R7: Writing a one to status bit 1, 2, 3, 4 or 7 clears that bit. Writing zero leaves a bit unchanged, and writing status bit 0 has no effect on busy.
- R8: A pulse on `eng_byte_done` during a transaction sets status bit 7 and raises `eng_hold` from the next cycle. `eng_hold` falls right after a status write with bit 7 set, and a status write without bit 7 leaves it high.
- R9: The strobes `eng_rx_d0_we`, `eng_rx_d1_we` and `eng_rx_blk_we` load `eng_rx_byte` into data0, data1 and block data. In the same cycle they win over a bus write to the same register.
- R10: `eng_count` equals data0 limited to the range 1 to 32: 0 gives 1, and values above 32 give 32.
- R11: The engine fields decode the registers as follows:
  - `eng_kind` is control bits [4:2], with 0 quick, 1 byte, 2 byte-data, 3 word-data and 5 block.
  - `eng_last` is control bit 5.
  - `eng_slave` is address bits [7:1].
  - `eng_read` is address bit 0.
  - `eng_pec` is auxiliary bit 0.
- R12: An engine event that arrives in the same cycle as a clearing write to its status bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_kind | output | 3 | Transaction kind |
| eng_last | output | 1 | Last byte of a block read |
| eng_pec | output | 1 | Hardware packet error checking enable |
| eng_slave | output | 7 | Slave address |
| eng_read | output | 1 | Direction, 1 = read |
| eng_cmd | output | 8 | Command byte |
| eng_data0 | output | 8 | Data0 register |
| eng_data1 | output | 8 | Data1 register |
| eng_count | output | CNT_W | Limited block byte count |
| eng_blk | output | 8 | Block-data register |
| eng_hold | output | 1 | Engine must wait for the byte handshake |
| eng_done | input | 1 | Transaction complete strobe |
| eng_dev_err | input | 1 | No-acknowledge strobe |
| eng_coll | input | 1 | Bus collision strobe |
| eng_failed | input | 1 | Failed transaction strobe |
| eng_byte_done | input | 1 | Block byte finished strobe |
| eng_rx_byte | input | 8 | Byte received by the engine |
| eng_rx_d0_we | input | 1 | Load `eng_rx_byte` into data0 |
| eng_rx_d1_we | input | 1 | Load `eng_rx_byte` into data1 |
| eng_rx_blk_we | input | 1 | Load `eng_rx_byte` into block data |

## Verification
The hardest situations to reach are those where a bus write and an engine strobe meet in the same cycle. One is a clearing write to a status bit while the engine sets that bit again. Another is a bus write to block data while the engine loads a received byte. The stimulus reaches both by driving the register strobe and the engine strobe on the same falling edge, so both are sampled by one rising edge. The byte handshake is reached by launching a block transaction, letting it settle into RUN, pulsing byte-done, and then writing the status register first without and then with bit 7. This shows that only the proper acknowledge releases the hold.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam int unsigned BYTE_W = 8;

    // register offsets; software drivers decode these
    localparam int unsigned OFF_STATUS = 0;
    localparam int unsigned OFF_CTRL   = 2;
    localparam int unsigned OFF_CMD    = 3;
    localparam int unsigned OFF_ADDR   = 4;
    localparam int unsigned OFF_DATA0  = 5;
    localparam int unsigned OFF_DATA1  = 6;
    localparam int unsigned OFF_BLOCK  = 7;
    localparam int unsigned OFF_AUX    = 13;

    // status bit positions
    localparam int unsigned ST_BUSY  = 0;
    localparam int unsigned ST_INTR  = 1;
    localparam int unsigned ST_DEV   = 2;
    localparam int unsigned ST_COLL  = 3;
    localparam int unsigned ST_FAIL  = 4;
    localparam int unsigned ST_BDONE = 7;

    // control bit positions
    localparam int unsigned CT_KIND_LO = 2;
    localparam int unsigned CT_KIND_HI = 4;
    localparam int unsigned CT_LAST    = 5;
    localparam int unsigned CT_START   = 6;

    // sticky event flags held in the flag bank (index order)
    localparam int unsigned FL_INTR  = 0;
    localparam int unsigned FL_DEV   = 1;
    localparam int unsigned FL_COLL  = 2;
    localparam int unsigned FL_FAIL  = 3;
    localparam int unsigned FL_BDONE = 4;
    localparam int unsigned NFLAG    = 5;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_LAUNCH,
        HS_RUN,
        HS_HOLD
    } host_state_e;

endpackage

// File: rtl/smb_host_fsm.sv
module smb_host_fsm
    import smb_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic end_evt,
    input  logic byte_evt,
    input  logic byte_ack,
    output logic busy,
    output logic start_pulse,
    output logic hold
);

    host_state_e state_q;
    host_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        busy        = 1'b1;
        start_pulse = 1'b0;
        hold        = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                busy = 1'b0;
                if (start_req) begin
                    state_d = HS_LAUNCH;
                end
            end
            HS_LAUNCH: begin
                start_pulse = 1'b1;
                if (end_evt) begin
                    state_d = HS_IDLE;
                end else if (byte_evt) begin
                    state_d = HS_HOLD;
                end else begin
                    state_d = HS_RUN;
                end
            end
            HS_RUN: begin
                if (end_evt) begin
                    state_d = HS_IDLE;
                end else if (byte_evt) begin
                    state_d = HS_HOLD;
                end
            end
            HS_HOLD: begin
                hold = 1'b1;
                if (end_evt) begin
                    state_d = HS_IDLE;
                end else if (byte_ack) begin
                    state_d = HS_RUN;
                end
            end
            default: begin
                state_d = HS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/smb_flag_bank.sv
module smb_flag_bank #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (set_i[i]) begin
                q <= 1'b1;          // a new event wins over a clear
            end else if (clr_i[i]) begin
                q <= 1'b0;
            end
        end
        assign flag_o[i] = q;
    end

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              cmd_we,
    input  logic              addr_we,
    input  logic              d0_we,
    input  logic              d1_we,
    input  logic              blk_we,
    input  logic              aux_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_d0_we,
    input  logic              rx_d1_we,
    input  logic              rx_blk_we,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [2:0]        kind_o,
    output logic              last_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [BYTE_W-1:0] d0_o,
    output logic [BYTE_W-1:0] d1_o,
    output logic [BYTE_W-1:0] blk_o,
    output logic              aux_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_o <= '0;
            last_o <= 1'b0;
            cmd_o  <= '0;
            addr_o <= '0;
            aux_o  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                kind_o <= wdata[CT_KIND_HI:CT_KIND_LO];
                last_o <= wdata[CT_LAST];
            end
            if (cmd_we)  cmd_o  <= wdata;
            if (addr_we) addr_o <= wdata;
            if (aux_we)  aux_o  <= wdata[0];
        end
    end

    // data registers shared with the engine; engine loads take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0_o  <= '0;
            d1_o  <= '0;
            blk_o <= '0;
        end else begin
            if (rx_d0_we)      d0_o <= rx_byte;
            else if (d0_we)    d0_o <= wdata;
            if (rx_d1_we)      d1_o <= rx_byte;
            else if (d1_we)    d1_o <= wdata;
            if (rx_blk_we)     blk_o <= rx_byte;
            else if (blk_we)   blk_o <= wdata;
        end
    end

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned MAX_BLOCK = 32,
    parameter int unsigned CNT_W     = $clog2(MAX_BLOCK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              eng_start,
    output logic [2:0]        eng_kind,
    output logic              eng_last,
    output logic              eng_pec,
    output logic [6:0]        eng_slave,
    output logic              eng_read,
    output logic [7:0]        eng_cmd,
    output logic [7:0]        eng_data0,
    output logic [7:0]        eng_data1,
    output logic [CNT_W-1:0]  eng_count,
    output logic [7:0]        eng_blk,
    output logic              eng_hold,
    input  logic              eng_done,
    input  logic              eng_dev_err,
    input  logic              eng_coll,
    input  logic              eng_failed,
    input  logic              eng_byte_done,
    input  logic [7:0]        eng_rx_byte,
    input  logic              eng_rx_d0_we,
    input  logic              eng_rx_d1_we,
    input  logic              eng_rx_blk_we
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_ADDR   = ADDR_W'(OFF_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA0  = ADDR_W'(OFF_DATA0);
    localparam logic [ADDR_W-1:0] A_DATA1  = ADDR_W'(OFF_DATA1);
    localparam logic [ADDR_W-1:0] A_BLOCK  = ADDR_W'(OFF_BLOCK);
    localparam logic [ADDR_W-1:0] A_AUX    = ADDR_W'(OFF_AUX);
    localparam logic [7:0]        CNT_MAX8 = 8'(MAX_BLOCK);

    logic             busy_w;
    logic             st_we;
    logic             ctrl_hit;
    logic             ctrl_start_wr;
    logic             ctrl_we;
    logic             byte_ack;
    logic             end_evt;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flags;
    logic             bd_flag;
    logic [2:0]       kind_q;
    logic             last_q;
    logic [7:0]       addr_q;
    logic             aux_q;
    logic [7:0]       status_rd;
    logic [7:0]       ctrl_rd;

    // bus write decode
    assign st_we         = reg_wr && (reg_addr == A_STATUS);
    assign ctrl_hit      = reg_wr && (reg_addr == A_CTRL);
    assign ctrl_start_wr = ctrl_hit && reg_wdata[CT_START];
    assign ctrl_we       = ctrl_hit && !(reg_wdata[CT_START] && busy_w);
    assign byte_ack      = st_we && reg_wdata[ST_BDONE];
    assign end_evt       = eng_done || eng_dev_err || eng_coll || eng_failed;

    smb_host_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (ctrl_start_wr),
        .end_evt    (end_evt),
        .byte_evt   (eng_byte_done),
        .byte_ack   (byte_ack),
        .busy       (busy_w),
        .start_pulse(eng_start),
        .hold       (eng_hold)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FL_INTR]  = eng_done;
        flag_set[FL_DEV]   = eng_dev_err;
        flag_set[FL_COLL]  = eng_coll;
        flag_set[FL_FAIL]  = eng_failed;
        flag_set[FL_BDONE] = eng_byte_done;
        flag_clr           = '0;
        flag_clr[FL_INTR]  = st_we && reg_wdata[ST_INTR];
        flag_clr[FL_DEV]   = st_we && reg_wdata[ST_DEV];
        flag_clr[FL_COLL]  = st_we && reg_wdata[ST_COLL];
        flag_clr[FL_FAIL]  = st_we && reg_wdata[ST_FAIL];
        flag_clr[FL_BDONE] = byte_ack;
    end

    smb_flag_bank #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .flag_o(flags)
    );

    assign bd_flag = flags[FL_BDONE];

    smb_reg_file u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .cmd_we   (reg_wr && (reg_addr == A_CMD)),
        .addr_we  (reg_wr && (reg_addr == A_ADDR)),
        .d0_we    (reg_wr && (reg_addr == A_DATA0)),
        .d1_we    (reg_wr && (reg_addr == A_DATA1)),
        .blk_we   (reg_wr && (reg_addr == A_BLOCK)),
        .aux_we   (reg_wr && (reg_addr == A_AUX)),
        .wdata    (reg_wdata),
        .rx_d0_we (eng_rx_d0_we),
        .rx_d1_we (eng_rx_d1_we),
        .rx_blk_we(eng_rx_blk_we),
        .rx_byte  (eng_rx_byte),
        .kind_o   (kind_q),
        .last_o   (last_q),
        .cmd_o    (eng_cmd),
        .addr_o   (addr_q),
        .d0_o     (eng_data0),
        .d1_o     (eng_data1),
        .blk_o    (eng_blk),
        .aux_o    (aux_q)
    );

    // engine-facing fields
    assign eng_kind  = kind_q;
    assign eng_last  = last_q;
    assign eng_pec   = aux_q;
    assign eng_slave = addr_q[7:1];
    assign eng_read  = addr_q[0];

    // block byte count limited to 1..MAX_BLOCK
    always_comb begin
        if (eng_data0 == 8'd0) begin
            eng_count = CNT_W'(1);
        end else if (eng_data0 > CNT_MAX8) begin
            eng_count = CNT_W'(MAX_BLOCK);
        end else begin
            eng_count = CNT_W'(eng_data0);
        end
    end

    // read-back assembly
    always_comb begin
        status_rd           = '0;
        status_rd[ST_BUSY]  = busy_w;
        status_rd[ST_INTR]  = flags[FL_INTR];
        status_rd[ST_DEV]   = flags[FL_DEV];
        status_rd[ST_COLL]  = flags[FL_COLL];
        status_rd[ST_FAIL]  = flags[FL_FAIL];
        status_rd[ST_BDONE] = flags[FL_BDONE];
        ctrl_rd                        = '0;
        ctrl_rd[CT_KIND_HI:CT_KIND_LO] = kind_q;
        ctrl_rd[CT_LAST]               = last_q;
    end

    always_comb begin
        case (reg_addr)
            A_STATUS: reg_rdata = status_rd;
            A_CTRL:   reg_rdata = ctrl_rd;
            A_CMD:    reg_rdata = eng_cmd;
            A_ADDR:   reg_rdata = addr_q;
            A_DATA0:  reg_rdata = eng_data0;
            A_DATA1:  reg_rdata = eng_data1;
            A_BLOCK:  reg_rdata = eng_blk;
            A_AUX:    reg_rdata = {7'd0, aux_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
    parameter int unsigned MAX_BLOCK = 32,
    parameter int unsigned CNT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_start,
    input logic             busy,
    input logic             start_wr,
    input logic             eng_done,
    input logic             eng_dev_err,
    input logic             eng_coll,
    input logic             eng_failed,
    input logic             eng_hold,
    input logic             bd_flag,
    input logic [CNT_W-1:0] eng_count
);

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    // R4
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_wr) |=> !eng_start);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> !busy);

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (eng_dev_err || eng_coll || eng_failed)) |=> !busy);

    // R8
    hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_hold |-> (bd_flag && busy));

    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_count >= CNT_W'(1)) && (eng_count <= CNT_W'(MAX_BLOCK)));

endmodule

bind smb_host_regs smb_host_regs_chk #(
    .MAX_BLOCK(MAX_BLOCK),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_start  (eng_start),
    .busy       (busy_w),
    .start_wr   (ctrl_start_wr),
    .eng_done   (eng_done),
    .eng_dev_err(eng_dev_err),
    .eng_coll   (eng_coll),
    .eng_failed (eng_failed),
    .eng_hold   (eng_hold),
    .bd_flag    (bd_flag),
    .eng_count  (eng_count)
);

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 11;

    // {offset, write data, expected read-back}  (R2)
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {4'd2,  8'hBF, 8'h3C},
        {4'd3,  8'hA5, 8'hA5},
        {4'd4,  8'h5B, 8'h5B},
        {4'd5,  8'h11, 8'h11},
        {4'd6,  8'hEE, 8'hEE},
        {4'd7,  8'h7E, 8'h7E},
        {4'd13, 8'hFF, 8'h01},
        {4'd9,  8'hFF, 8'h00},
        {4'd1,  8'hFF, 8'h00},
        {4'd15, 8'hAA, 8'h00},
        {4'd0,  8'hFF, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_start, eng_last, eng_pec, eng_read, eng_hold;
    logic [2:0] eng_kind;
    logic [6:0] eng_slave;
    logic [7:0] eng_cmd, eng_data0, eng_data1, eng_blk;
    logic [5:0] eng_count;
    logic       eng_done = 0, eng_dev_err = 0, eng_coll = 0, eng_failed = 0;
    logic       eng_byte_done = 0;
    logic [7:0] eng_rx_byte = '0;
    logic       eng_rx_d0_we = 0, eng_rx_d1_we = 0, eng_rx_blk_we = 0;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_kind(eng_kind), .eng_last(eng_last), .eng_pec(eng_pec),
        .eng_slave(eng_slave), .eng_read(eng_read), .eng_cmd(eng_cmd),
        .eng_data0(eng_data0), .eng_data1(eng_data1), .eng_count(eng_count),
        .eng_blk(eng_blk), .eng_hold(eng_hold), .eng_done(eng_done),
        .eng_dev_err(eng_dev_err), .eng_coll(eng_coll), .eng_failed(eng_failed),
        .eng_byte_done(eng_byte_done), .eng_rx_byte(eng_rx_byte),
        .eng_rx_d0_we(eng_rx_d0_we), .eng_rx_d1_we(eng_rx_d1_we),
        .eng_rx_blk_we(eng_rx_blk_we)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // kind: 0 done, 1 dev err, 2 collision, 3 failed, 4 byte done
    task automatic eng_pulse(input int kind);
        @(negedge clk);
        eng_done      = (kind == 0);
        eng_dev_err   = (kind == 1);
        eng_coll      = (kind == 2);
        eng_failed    = (kind == 3);
        eng_byte_done = (kind == 4);
        @(negedge clk);
        eng_done = 0; eng_dev_err = 0; eng_coll = 0; eng_failed = 0; eng_byte_done = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v); check("R1 status", v, 8'h00);
        rd(4'd2, v); check("R1 control", v, 8'h00);
        rd(4'd5, v); check("R1 data0", v, 8'h00);
        check("R1 start", {7'd0, eng_start}, 8'h00);
        check("R1 hold", {7'd0, eng_hold}, 8'h00);
        check("R1 count", {2'd0, eng_count}, 8'h01);

        // R2 table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], v);
            check("R2 readback", v, VEC[i][7:0]);
        end

        // R10 count limiting (data0 = 0x11 from table)
        check("R10 count 17", {2'd0, eng_count}, 8'd17);
        wr(4'd5, 8'd0);  check("R10 count 0", {2'd0, eng_count}, 8'd1);
        wr(4'd5, 8'd40); check("R10 count 40", {2'd0, eng_count}, 8'd32);
        wr(4'd5, 8'd32); check("R10 count 32", {2'd0, eng_count}, 8'd32);
        wr(4'd5, 8'd33); check("R10 count 33", {2'd0, eng_count}, 8'd32);

        // R11 field decode
        wr(4'd4, 8'hA3);
        check("R11 slave", {1'b0, eng_slave}, 8'h51);
        check("R11 read", {7'd0, eng_read}, 8'h01);
        wr(4'd2, 8'h34);
        check("R11 kind", {5'd0, eng_kind}, 8'h05);
        check("R11 last", {7'd0, eng_last}, 8'h01);
        wr(4'd13, 8'h01); check("R11 pec on", {7'd0, eng_pec}, 8'h01);
        wr(4'd13, 8'hFE); check("R11 pec off", {7'd0, eng_pec}, 8'h00);

        // R3 start strobe, byte-data kind
        wr(4'd2, 8'h48);
        check("R3 start high", {7'd0, eng_start}, 8'h01);
        rd(4'd0, v); check("R3 busy", v, 8'h01);
        @(negedge clk);
        check("R3 start one cycle", {7'd0, eng_start}, 8'h00);
        rd(4'd2, v); check("R3 ctrl no start bit", v, 8'h08);

        // R4 start while busy ignored
        wr(4'd2, 8'h54);
        check("R4 no start", {7'd0, eng_start}, 8'h00);
        rd(4'd2, v); check("R4 ctrl unchanged", v, 8'h08);

        // R5 done
        eng_pulse(0);
        rd(4'd0, v); check("R5 done", v, 8'h02);

        // R7 write-one-to-clear
        wr(4'd0, 8'h01); rd(4'd0, v); check("R7 busy bit write", v, 8'h02);
        wr(4'd0, 8'h00); rd(4'd0, v); check("R7 zero write", v, 8'h02);
        wr(4'd0, 8'h02); rd(4'd0, v); check("R7 clear intr", v, 8'h00);

        // R6 errors end the transaction
        wr(4'd2, 8'h44); eng_pulse(1);
        rd(4'd0, v); check("R6 dev err", v, 8'h04);
        wr(4'd0, 8'h04);
        wr(4'd2, 8'h44); eng_pulse(2);
        rd(4'd0, v); check("R6 collision", v, 8'h08);
        wr(4'd0, 8'h08);
        wr(4'd2, 8'h44); eng_pulse(3);
        rd(4'd0, v); check("R6 failed", v, 8'h10);
        wr(4'd0, 8'h10);
        rd(4'd0, v); check("R7 all clear", v, 8'h00);

        // R8 byte handshake during a block transaction
        wr(4'd2, 8'h54);
        @(negedge clk);
        eng_pulse(4);
        rd(4'd0, v); check("R8 flag set", v, 8'h81);
        check("R8 hold high", {7'd0, eng_hold}, 8'h01);
        wr(4'd0, 8'h01);
        check("R8 hold kept", {7'd0, eng_hold}, 8'h01);
        rd(4'd0, v); check("R8 flag kept", v, 8'h81);
        wr(4'd0, 8'h80);
        check("R8 hold released", {7'd0, eng_hold}, 8'h00);
        rd(4'd0, v); check("R8 flag cleared", v, 8'h01);
        eng_pulse(0);
        wr(4'd0, 8'h02);

        // R9 engine loads, priority over bus
        @(negedge clk);
        eng_rx_byte = 8'h3C; eng_rx_d1_we = 1;
        @(negedge clk);
        eng_rx_d1_we = 0;
        rd(4'd6, v); check("R9 data1 load", v, 8'h3C);
        reg_wr = 1; reg_addr = 4'd7; reg_wdata = 8'h11;
        eng_rx_byte = 8'h66; eng_rx_blk_we = 1;
        @(negedge clk);
        reg_wr = 0; eng_rx_blk_we = 0;
        rd(4'd7, v); check("R9 block priority", v, 8'h66);
        eng_rx_byte = 8'h9C; eng_rx_d0_we = 1;
        @(negedge clk);
        eng_rx_d0_we = 0;
        rd(4'd5, v); check("R9 data0 load", v, 8'h9C);

        // R12 set wins over a simultaneous clear
        reg_wr = 1; reg_addr = 4'd0; reg_wdata = 8'h04; eng_dev_err = 1;
        @(negedge clk);
        reg_wr = 0; eng_dev_err = 0;
        rd(4'd0, v); check("R12 set wins", v, 8'h04);
        wr(4'd0, 8'h04);
        rd(4'd0, v); check("R12 later clear", v, 8'h00);

        summary();
    end

endmodule